// File: doc/BRIEF.md
# Rate-Folding Sample Packer

This block sits between the per-phase sampling front end of a capture channel bank and the storage memory. Every base sample period it receives all probe channels sampled at four equally spaced sub-phases. It turns them into one storage word of fixed width. A rate selector trades channel count for time resolution. At base rate every channel is stored once. At double rate the lower half of the channels is stored twice per period. At quadruple rate the lowest quarter is stored four times per period.

Each stored word carries a valid flag. It also reports the spacing, in finest-resolution ticks, between the time slices it holds. The timestamp logic downstream always counts in finest ticks, whatever the rate. A new rate setting is picked up only together with a sample period. The first word stored under a different rate is marked as a discontinuity, and so is the first word after reset.

Top module: `rate_fold_packer`

## Requirements
- R1: While reset is asserted and after its release with no sample offered, `word_valid_o` is 0, `word_o` is all zeros, `disc_o` is 0 and `tick_step_o` is 4.
- R2: With `rate_sel_i` = 0 (base rate), the stored word holds phase 0 of every channel: bit c of `word_o` equals bit c of phase slice 0. Phase p occupies `smp_i[p*NCH +: NCH]`, and phase 0 is the earliest.
- R3: With `rate_sel_i` = 1 (double rate), `word_o[NCH/2-1:0]` holds channels 0..NCH/2-1 at phase 0 and `word_o[NCH-1:NCH/2]` holds the same channels at phase 2. The earliest slice is least significant.
- R4: With `rate_sel_i` = 2 (quadruple rate), slice k of width NCH/4 in `word_o` holds channels 0..NCH/4-1 at phase k, for k = 0..3.
- R5: Channels outside the active set, and phases that the active rate does not use, have no effect on `word_o`.
- R6: `tick_step_o` reports the fine-tick spacing of the stored word: 4 at base rate, 2 at double rate, 1 at quadruple rate.
- R7: The word is registered one clock after `smp_valid_i` is high. `word_valid_o` is high for exactly those cycles. With no sample offered, `word_o`, `tick_step_o` and `disc_o` hold their values.
- R8: `rate_sel_i` is taken only in a cycle with `smp_valid_i` high. Changes while idle have no effect until the next sample.
- R9: `disc_o` is high with a stored word when the word is the first one since reset or its rate differs from that of the previous stored word. The reserved code 3 acts as base rate, so a switch between 3 and 0 is not a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per base sample period |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | A full set of phase samples is present |
| smp_i | input | 4*NCH | Phase samples, phase p at [p*NCH +: NCH] |
| rate_sel_i | input | 2 | 0 base rate, 1 double, 2 quadruple, 3 as 0 |
| word_o | output | NCH | Packed storage word |
| word_valid_o | output | 1 | Stored word present |
| tick_step_o | output | 3 | Fine-tick spacing of the word's slices |
| disc_o | output | 1 | Rate discontinuity at this word |

## Verification
The assertions take for granted that reset is only asserted between whole sample periods. They also assume that `rate_sel_i` carries a known value whenever `smp_valid_i` is high. The discontinuity check relies on the previous word's spacing being held through idle cycles. That only holds if no sample arrives while reset is released part-way through a cycle. The stimulus changes inputs only on the falling clock edge and releases reset between edges. It always drives a defined rate code, including the reserved code 3.

// File: rtl/fold_pkg.sv
package fold_pkg;
  localparam int unsigned PHASES = 4;

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X2  = 2'd1,
    RATE_X4  = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;

  function automatic rate_e rate_norm(logic [1:0] sel);
    rate_e r;
    r = rate_e'(sel);
    if (r == RATE_RSV) r = RATE_X1;
    return r;
  endfunction

  function automatic logic [2:0] tick_of(rate_e r);
    logic [2:0] t;
    case (r)
      RATE_X4: t = 3'd1;
      RATE_X2: t = 3'd2;
      default: t = 3'd4;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/fold_slicer.sv
module fold_slicer
  import fold_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic [PHASES*NCH-1:0] smp_i,
  input  rate_e                 rate_i,
  output logic [NCH-1:0]        word_o
);
  localparam int unsigned HALF = NCH / 2;
  localparam int unsigned QTR  = NCH / 4;

  logic [NCH-1:0] w_x1;
  logic [NCH-1:0] w_x2;
  logic [NCH-1:0] w_x4;

  assign w_x1 = smp_i[NCH-1:0];

  // double rate: slice j takes phase 2j of the lower half
  for (genvar j = 0; j < 2; j++) begin : g_x2
    assign w_x2[j*HALF +: HALF] = smp_i[(2*j)*NCH +: HALF];
  end

  // quadruple rate: slice k takes phase k of the lowest quarter
  for (genvar k = 0; k < 4; k++) begin : g_x4
    assign w_x4[k*QTR +: QTR] = smp_i[k*NCH +: QTR];
  end

  always_comb begin
    case (rate_i)
      RATE_X2: word_o = w_x2;
      RATE_X4: word_o = w_x4;
      default: word_o = w_x1;
    endcase
  end
endmodule

// File: rtl/fold_rate_ctl.sv
module fold_rate_ctl
  import fold_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic [1:0] sel_i,
  output rate_e      rate_o,
  output logic       disc_d_o
);
  rate_e last_q, last_d;
  logic  seen_q, seen_d;

  assign rate_o = rate_norm(sel_i);

  always_comb begin
    last_d   = last_q;
    seen_d   = seen_q;
    disc_d_o = 1'b0;
    if (take_i) begin
      disc_d_o = !seen_q || (rate_o != last_q);
      last_d   = rate_o;
      seen_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= RATE_X1;
      seen_q <= 1'b0;
    end else if (take_i) begin
      last_q <= last_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/rate_fold_packer.sv
module rate_fold_packer
  import fold_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  smp_valid_i,
  input  logic [PHASES*NCH-1:0] smp_i,
  input  logic [1:0]            rate_sel_i,
  output logic [NCH-1:0]        word_o,
  output logic                  word_valid_o,
  output logic [2:0]            tick_step_o,
  output logic                  disc_o
);
  rate_e          rate;
  logic           disc_d;
  logic [NCH-1:0] packed_w;

  logic [NCH-1:0] word_q, word_d;
  logic           valid_q, valid_d;
  logic [2:0]     tick_q, tick_d;
  logic           disc_q, disc_nx;

  fold_rate_ctl i_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (smp_valid_i),
    .sel_i   (rate_sel_i),
    .rate_o  (rate),
    .disc_d_o(disc_d)
  );

  fold_slicer #(.NCH(NCH)) i_slicer (
    .smp_i (smp_i),
    .rate_i(rate),
    .word_o(packed_w)
  );

  always_comb begin
    word_d  = word_q;
    tick_d  = tick_q;
    disc_nx = disc_q;
    valid_d = smp_valid_i;
    if (smp_valid_i) begin
      word_d  = packed_w;
      tick_d  = tick_of(rate);
      disc_nx = disc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      tick_q <= 3'd4;
      disc_q <= 1'b0;
    end else if (smp_valid_i) begin
      word_q <= word_d;
      tick_q <= tick_d;
      disc_q <= disc_nx;
    end
  end

  assign word_o       = word_q;
  assign word_valid_o = valid_q;
  assign tick_step_o  = tick_q;
  assign disc_o       = disc_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> word_valid_o);  // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !word_valid_o);  // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(word_o) && $stable(tick_step_o) && $stable(disc_o)));  // R7
  AST_TICK_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tick_step_o) == 1);  // R6
  AST_DISC_WITH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disc_o && !$stable(disc_o)) |-> word_valid_o);  // R9
  AST_SAME_RATE_SAME_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !disc_o) |-> $stable(tick_step_o));  // R9
endmodule

// File: tb/test_rate_fold_packer.sv
`timescale 1ns/1ps
module test_rate_fold_packer;
  localparam int unsigned NCH = 16;
  localparam int unsigned NV  = 8;

  localparam logic [63:0] VEC_SMP [NV] = '{
    64'h0123_4567_89AB_CDEF,
    64'hFFFF_0000_FFFF_A5A5,
    64'h1111_2222_3333_4444,
    64'hDEAD_BEEF_CAFE_F00D,
    64'h8421_1248_F0F0_0F0F,
    64'h7777_EEEE_5555_AAAA,
    64'h0000_FFFF_0000_1234,
    64'h9999_6666_C3C3_3C3C
  };
  localparam logic [1:0] VEC_SEL [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd0};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              smp_valid;
  logic [4*NCH-1:0]  smp;
  logic [1:0]        rate_sel;
  logic [NCH-1:0]    word;
  logic              word_valid;
  logic [2:0]        tick_step;
  logic              disc;

  int n_chk = 0;
  int n_bad = 0;
  logic       m_seen;
  logic [1:0] m_last;

  always #2.5 clk = ~clk;

  rate_fold_packer #(.NCH(NCH)) i_rate_fold_packer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_valid_i (smp_valid),
    .smp_i       (smp),
    .rate_sel_i  (rate_sel),
    .word_o      (word),
    .word_valid_o(word_valid),
    .tick_step_o (tick_step),
    .disc_o      (disc)
  );

  function automatic logic [1:0] eff(logic [1:0] s);
    return (s == 2'd3) ? 2'd0 : s;
  endfunction

  function automatic logic [NCH-1:0] exp_word(logic [4*NCH-1:0] s, logic [1:0] sel);
    logic [NCH-1:0] w;
    w = '0;
    case (eff(sel))
      2'd1: for (int j = 0; j < 2; j++)
              for (int c = 0; c < NCH/2; c++) w[j*(NCH/2)+c] = s[(2*j)*NCH + c];
      2'd2: for (int k = 0; k < 4; k++)
              for (int c = 0; c < NCH/4; c++) w[k*(NCH/4)+c] = s[k*NCH + c];
      default: for (int c = 0; c < NCH; c++) w[c] = s[c];
    endcase
    return w;
  endfunction

  function automatic logic [2:0] exp_tick(logic [1:0] sel);
    case (eff(sel))
      2'd1: return 3'd2;
      2'd2: return 3'd1;
      default: return 3'd4;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one sample on a falling edge, check the stored word one clock later
  task automatic push(logic [63:0] s, logic [1:0] sel, string req);
    logic exp_disc;
    @(negedge clk);
    smp_valid = 1'b1; smp = s; rate_sel = sel;
    exp_disc = !m_seen || (eff(sel) != m_last);
    m_seen = 1'b1; m_last = eff(sel);
    @(negedge clk);
    smp_valid = 1'b0;
    chk(word_valid == 1'b1, {req, " R7 valid"}, 64'(word_valid), 64'd1);
    chk(word == exp_word(s, sel), {req, " word"}, 64'(word), 64'(exp_word(s, sel)));
    chk(tick_step == exp_tick(sel), "R6 tick", 64'(tick_step), 64'(exp_tick(sel)));
    chk(disc == exp_disc, "R9 disc", 64'(disc), 64'(exp_disc));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_valid = 1'b0; smp = '0; rate_sel = 2'd0;
    m_seen = 1'b0; m_last = 2'd0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [NCH-1:0] held;
    do_reset();
    chk(word_valid == 1'b0, "R1 valid", 64'(word_valid), 64'd0);
    chk(word == '0, "R1 word", 64'(word), 64'd0);
    chk(disc == 1'b0, "R1 disc", 64'(disc), 64'd0);
    chk(tick_step == 3'd4, "R1 tick", 64'(tick_step), 64'd4);

    for (int i = 0; i < NV; i++) begin
      case (eff(VEC_SEL[i]))
        2'd1:    push(VEC_SMP[i], VEC_SEL[i], "R3");
        2'd2:    push(VEC_SMP[i], VEC_SEL[i], "R4");
        default: push(VEC_SMP[i], VEC_SEL[i], "R2");
      endcase
    end

    // R8 / R7: rate change while idle, outputs hold
    held = word;
    @(negedge clk); rate_sel = 2'd2;
    repeat (3) begin
      @(negedge clk);
      chk(word_valid == 1'b0, "R7 idle valid", 64'(word_valid), 64'd0);
      chk(word == held, "R7 idle hold", 64'(word), 64'(held));
    end
    push(64'hABCD_1234_5678_9ABC, 2'd0, "R8");

    // R5: unused channels and phases do not leak
    push(64'hFFF0_FFF0_FFF0_FFF0, 2'd2, "R5 x4 upper");
    push(64'hFF00_FFFF_FF00_FFFF, 2'd1, "R5 x2 upper");
    push(64'hFFFF_FFFF_FFFF_0000, 2'd0, "R5 x1 phases");
    chk(word == '0, "R5 zero word", 64'(word), 64'd0);

    // R9: switch between reserved code and base rate is not a change
    push(64'h0F0F_0F0F_0F0F_0F0F, 2'd3, "R9 rsv");
    chk(disc == 1'b0, "R9 rsv no disc", 64'(disc), 64'd0);

    // R1 / R9: reset mid-run, first word flagged again
    do_reset();
    chk(word_valid == 1'b0 && word == '0, "R1 re-reset", 64'(word), 64'd0);
    push(64'h5A5A_5A5A_5A5A_5A5A, 2'd1, "R9 after reset");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule